// File: doc/BRIEF.md
# DMA Interrupt Cause Collector

This block gathers the interrupt events of a DMA channel into a sticky status register. Six event inputs feed fixed, sparse bit positions. An enable register masks the status, and the masked result is the interrupt cause. Software reads the status and enable words through a small register port. It clears status bits by writing ones to a separate clear register.

Two delivery styles are supported, chosen by a small control register. In wired mode the block holds a level interrupt high for as long as any enabled status bit is set. In message mode the level output stays low. Instead, each time an event newly sets an enabled bit, the block issues a one-cycle pulse that carries the cause word. An error-summary output flags any enabled error-class bit, so the channel logic around the block can stop work without decoding the cause.

Top module: `irq_cause_unit`

## Requirements
- R1: Events map to status bits as follows: end of block to bit 0, event write-response error to bit 1, descriptor read error to bit 9, data read error to bit 10, data write error to bit 11, invalid descriptor to bit 14. Status reads at offset 0x100, and every other status bit reads 0. A set bit stays set until it is cleared.
- R2: Writing to the clear register at offset 0x108 clears each status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged. The clear register reads as 0.
- R3: When an event arrives in the same cycle as a clear of its bit, the bit is set after that cycle.
- R4: The enable register at offset 0x110 is readable, and only the six implemented bits (mask 0x4E03) store a value. Writing 0 to it masks every interrupt and leaves the status bits unchanged.
- R5: In wired mode, irq_level is high exactly while some bit of status AND enable is set.
- R6: The control register at offset 0x004 stores 4 bits. Its bit 0 selects wired mode when 1 and message mode when 0. In message mode, irq_level is low.
- R7: In message mode, msg_valid is high for one cycle, in the cycle after an event sets a previously clear bit that is enabled. While it is high, msg_cause equals status AND enable. An event on a bit that is already set, or on a disabled bit, gives no pulse.
- R8: err_any is high exactly while some enabled status bit among 1, 9, 10, 11 and 14 is set. Bit 0 alone never raises it.
- R9: After reset, status and enable are 0, control is 0x1 (wired mode), and irq_level, msg_valid and err_any are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_end_blk | input | 1 | End-of-block completion event |
| ev_wresp_err | input | 1 | Event write-response error |
| ev_desc_rd_err | input | 1 | Descriptor read error |
| ev_data_rd_err | input | 1 | Data read error |
| ev_data_wr_err | input | 1 | Data write error |
| ev_bad_desc | input | 1 | Invalid descriptor event |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write offset |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read offset |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| irq_level | output | 1 | Level interrupt (wired mode) |
| msg_valid | output | 1 | One-cycle message pulse |
| msg_cause | output | DATA_W | Cause word carried by the pulse |
| err_any | output | 1 | Enabled error-class bit pending |

## Verification
The assertions assume that each event is a single-cycle strobe, and that the register port makes at most one write per cycle with no undriven address bits. They also assume that the mode bit changes only through a control write, so a pulse can be tied to the mode of the previous cycle. The bench drives events and writes only at the falling edge, and releases them at the next falling edge. It never writes two registers in one cycle. It runs the simultaneous event-and-clear case on purpose, with a clear of all ones, to show that the event wins.

// File: rtl/irq_cause_pkg.sv
// Package: shared bit positions, masks and register offsets for the
// interrupt cause collector. Assumes a data word of at least 15 bits.
package irq_cause_pkg;
    localparam int unsigned NUM_SRC = 6;

    // Source index order inside the event vector (not the status order).
    localparam int unsigned SRC_END_BLK   = 0;
    localparam int unsigned SRC_WRESP     = 1;
    localparam int unsigned SRC_DESC_RD   = 2;
    localparam int unsigned SRC_DATA_RD   = 3;
    localparam int unsigned SRC_DATA_WR   = 4;
    localparam int unsigned SRC_BAD_DESC  = 5;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    // Status bit position for each source index; software decodes these.
    function automatic int unsigned src_pos(int unsigned idx);
        case (idx)
            SRC_END_BLK:  return 0;
            SRC_WRESP:    return 1;
            SRC_DESC_RD:  return 9;
            SRC_DATA_RD:  return 10;
            SRC_DATA_WR:  return 11;
            default:      return 14;
        endcase
    endfunction

    // Whether a source belongs to the error class.
    function automatic logic src_is_err(int unsigned idx);
        return idx != SRC_END_BLK;
    endfunction

    function automatic logic [31:0] build_mask(logic only_err);
        logic [31:0] m;
        m = '0;
        for (int unsigned i = 0; i < NUM_SRC; i++) begin
            if (!only_err || src_is_err(i)) m[src_pos(i)] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [31:0] IMPL_MASK = build_mask(1'b0);
    localparam logic [31:0] ERR_MASK  = build_mask(1'b1);

    localparam logic [11:0] OFS_CTRL   = 12'h004;
    localparam logic [11:0] OFS_STATUS = 12'h100;
    localparam logic [11:0] OFS_CLEAR  = 12'h108;
    localparam logic [11:0] OFS_ENABLE = 12'h110;

    localparam int unsigned CTRL_W = 4;
    localparam logic [CTRL_W-1:0] CTRL_RESET = 4'h1;
endpackage

// File: rtl/irq_status_reg.sv
// Sticky status register with write-one-to-clear.
// Each source maps to its fixed status bit. A set request beats a clear
// of the same bit in the same cycle. Assumes single-cycle event strobes.
module irq_status_reg
    import irq_cause_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  src_vec_t          src,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] clr_data,
    output logic [DATA_W-1:0] status_q,
    output logic [DATA_W-1:0] status_d,
    output logic [DATA_W-1:0] new_bits
);
    localparam logic [DATA_W-1:0] MASK = IMPL_MASK[DATA_W-1:0];

    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] clr_vec;

    // Scatter the event vector onto the sparse status positions.
    always_comb begin
        set_vec = '0;
        for (int unsigned i = 0; i < NUM_SRC; i++) begin
            set_vec[src_pos(i)] = src[i];
        end
    end

    // Next status: clear first, then let new events set their bits.
    always_comb begin
        clr_vec  = clr_we ? (clr_data & MASK) : '0;
        status_d = ((status_q & ~clr_vec) | set_vec) & MASK;
        new_bits = set_vec & ~status_q;
    end

    // Status storage.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end
endmodule

// File: rtl/irq_regfile.sv
// Enable and control registers plus the read multiplexer.
// Assumes at most one write per cycle; unknown offsets read as zero,
// and the clear register always reads as zero.
module irq_regfile
    import irq_cause_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] status_q,
    output logic              clr_we,
    output logic [DATA_W-1:0] enable_q,
    output logic              mode_wired,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [DATA_W-1:0] MASK    = IMPL_MASK[DATA_W-1:0];
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFS_CLEAR);
    localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(OFS_ENABLE);

    logic [CTRL_W-1:0] ctrl_q;

    // Write decode for the clear register.
    assign clr_we     = wr_en && (wr_addr == A_CLR);
    assign mode_wired = ctrl_q[0];

    // Enable register: implemented bits only.
    always_ff @(posedge clk) begin
        if (!rst_n)                          enable_q <= '0;
        else if (wr_en && wr_addr == A_EN)   enable_q <= wr_data & MASK;
    end

    // Control register: low bits hold the delivery mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ctrl_q <= CTRL_RESET;
        else if (wr_en && wr_addr == A_CTRL) ctrl_q <= wr_data[CTRL_W-1:0];
    end

    // Read multiplexer.
    always_comb begin
        rd_data = '0;
        if (rd_addr == A_STAT)      rd_data = status_q;
        else if (rd_addr == A_EN)   rd_data = enable_q;
        else if (rd_addr == A_CTRL) rd_data = DATA_W'(ctrl_q);
    end
endmodule

// File: rtl/irq_deliver.sv
// Delivery stage: level interrupt in wired mode, registered one-cycle
// message pulse with the cause word in message mode, error summary.
// Assumes status and enable arrive straight from their registers.
module irq_deliver
    import irq_cause_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wired,
    input  logic [DATA_W-1:0] status_q,
    input  logic [DATA_W-1:0] status_d,
    input  logic [DATA_W-1:0] new_bits,
    input  logic [DATA_W-1:0] enable_q,
    output logic              irq_level,
    output logic              err_any,
    output logic              msg_valid,
    output logic [DATA_W-1:0] msg_cause
);
    localparam logic [DATA_W-1:0] EMASK = ERR_MASK[DATA_W-1:0];

    logic [DATA_W-1:0] cause;

    // Masked cause and the two level outputs.
    always_comb begin
        cause     = status_q & enable_q;
        irq_level = mode_wired && (|cause);
        err_any   = |(cause & EMASK);
    end

    // Message pulse on a freshly set enabled bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_cause <= '0;
        end else begin
            msg_valid <= !mode_wired && (|(new_bits & enable_q));
            msg_cause <= status_d & enable_q;
        end
    end
endmodule

// File: rtl/irq_cause_unit.sv
// Top: DMA interrupt cause collector. Ties together the status register,
// the enable/control register file and the delivery stage.
// Assumes ADDR_W >= 12 and DATA_W >= 15.
module irq_cause_unit
    import irq_cause_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_end_blk,
    input  logic              ev_wresp_err,
    input  logic              ev_desc_rd_err,
    input  logic              ev_data_rd_err,
    input  logic              ev_data_wr_err,
    input  logic              ev_bad_desc,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_level,
    output logic              msg_valid,
    output logic [DATA_W-1:0] msg_cause,
    output logic              err_any
);
    src_vec_t          src;
    logic              clr_we;
    logic              mode_wired;
    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] status_d;
    logic [DATA_W-1:0] new_bits;
    logic [DATA_W-1:0] enable_q;

    // Gather event inputs into the source vector.
    always_comb begin
        src                = '0;
        src[SRC_END_BLK]   = ev_end_blk;
        src[SRC_WRESP]     = ev_wresp_err;
        src[SRC_DESC_RD]   = ev_desc_rd_err;
        src[SRC_DATA_RD]   = ev_data_rd_err;
        src[SRC_DATA_WR]   = ev_data_wr_err;
        src[SRC_BAD_DESC]  = ev_bad_desc;
    end

    irq_status_reg #(.DATA_W(DATA_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src),
        .clr_we   (clr_we),
        .clr_data (wr_data),
        .status_q (status_q),
        .status_d (status_d),
        .new_bits (new_bits)
    );

    irq_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .status_q   (status_q),
        .clr_we     (clr_we),
        .enable_q   (enable_q),
        .mode_wired (mode_wired),
        .rd_data    (rd_data)
    );

    irq_deliver #(.DATA_W(DATA_W)) u_deliver (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wired (mode_wired),
        .status_q   (status_q),
        .status_d   (status_d),
        .new_bits   (new_bits),
        .enable_q   (enable_q),
        .irq_level  (irq_level),
        .err_any    (err_any),
        .msg_valid  (msg_valid),
        .msg_cause  (msg_cause)
    );
endmodule

// File: rtl/irq_cause_unit_chk.sv
// Checker for irq_cause_unit, bound below. Relates event and write ports
// to the stored status and the delivery outputs over time.
module irq_cause_unit_chk
    import irq_cause_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_end_blk,
    input logic              ev_wresp_err,
    input logic              ev_desc_rd_err,
    input logic              ev_data_rd_err,
    input logic              ev_data_wr_err,
    input logic              ev_bad_desc,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              irq_level,
    input logic              msg_valid,
    input logic [DATA_W-1:0] msg_cause,
    input logic              err_any,
    input logic [DATA_W-1:0] status_q,
    input logic [DATA_W-1:0] enable_q,
    input logic              mode_wired
);
    localparam logic [DATA_W-1:0] MASK  = IMPL_MASK[DATA_W-1:0];
    localparam logic [DATA_W-1:0] EMASK = ERR_MASK[DATA_W-1:0];
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_CLEAR);

    logic [DATA_W-1:0] ev_pos;

    // Event inputs placed at their expected status positions.
    always_comb begin
        ev_pos     = '0;
        ev_pos[0]  = ev_end_blk;
        ev_pos[1]  = ev_wresp_err;
        ev_pos[9]  = ev_desc_rd_err;
        ev_pos[10] = ev_data_rd_err;
        ev_pos[11] = ev_data_wr_err;
        ev_pos[14] = ev_bad_desc;
    end

    a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & ~MASK) == '0);

    a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_pos) |=> ((status_q & $past(ev_pos)) == $past(ev_pos)));

    a_r2_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CLR) |=> ((status_q & $past(wr_data & ~ev_pos)) == '0));

    a_r5_level_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wired && (|(status_q & enable_q))) |-> irq_level);

    a_r6_msg_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wired |-> !irq_level);

    a_r7_pulse_mode: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> ($past(!mode_wired) && msg_cause != '0));

    a_r8_err_source: assert property (@(posedge clk) disable iff (!rst_n)
        err_any |-> (|(status_q & enable_q & EMASK)));
endmodule

bind irq_cause_unit irq_cause_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ev_end_blk     (ev_end_blk),
    .ev_wresp_err   (ev_wresp_err),
    .ev_desc_rd_err (ev_desc_rd_err),
    .ev_data_rd_err (ev_data_rd_err),
    .ev_data_wr_err (ev_data_wr_err),
    .ev_bad_desc    (ev_bad_desc),
    .wr_en          (wr_en),
    .wr_addr        (wr_addr),
    .wr_data        (wr_data),
    .irq_level      (irq_level),
    .msg_valid      (msg_valid),
    .msg_cause      (msg_cause),
    .err_any        (err_any),
    .status_q       (status_q),
    .enable_q       (enable_q),
    .mode_wired     (mode_wired)
);

// File: tb/irq_cause_unit_test.sv
// Bench: vector table walk, then directed reset, register and message tests.
module irq_cause_unit_test;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam logic [11:0] A_CTRL = 12'h004;
    localparam logic [11:0] A_STAT = 12'h100;
    localparam logic [11:0] A_CLR  = 12'h108;
    localparam logic [11:0] A_EN   = 12'h110;

    // Row: events {bad,dwr,drd,desc,wresp,eob}, write, addr, data,
    // expected status, irq_level, err_any.
    typedef struct packed {
        logic [5:0]  ev;
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp_stat;
        logic        exp_irq;
        logic        exp_err;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{6'b000001, 1'b0, 12'h000, 32'h0,        32'h0001, 1'b1, 1'b0}, // R1 eob bit 0
        '{6'b001000, 1'b0, 12'h000, 32'h0,        32'h0401, 1'b1, 1'b1}, // R1 data read bit 10
        '{6'b000000, 1'b1, A_CLR,   32'h0001,     32'h0400, 1'b1, 1'b1}, // R2 clear one bit
        '{6'b000000, 1'b1, A_CLR,   32'h0400,     32'h0000, 1'b0, 1'b0}, // R2 clear last
        '{6'b100010, 1'b0, 12'h000, 32'h0,        32'h4002, 1'b1, 1'b1}, // R1 bits 14 and 1
        '{6'b000100, 1'b1, A_CLR,   32'hFFFFFFFF, 32'h0200, 1'b1, 1'b1}, // R3 event wins
        '{6'b000000, 1'b1, A_CLR,   32'h0,        32'h0200, 1'b1, 1'b1}, // R2 zero no effect
        '{6'b000000, 1'b1, A_EN,    32'h0,        32'h0200, 1'b0, 1'b0}, // R4 mask keeps status
        '{6'b000000, 1'b1, A_EN,    32'h0200,     32'h0200, 1'b1, 1'b1}, // R5 re-enable
        '{6'b000000, 1'b1, A_CLR,   32'h0200,     32'h0000, 1'b0, 1'b0}  // R5 level drops
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [5:0]        ev = '0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = A_STAT;
    logic [DATA_W-1:0] rd_data;
    logic              irq_level;
    logic              msg_valid;
    logic [DATA_W-1:0] msg_cause;
    logic              err_any;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    irq_cause_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .ev_end_blk     (ev[0]),
        .ev_wresp_err   (ev[1]),
        .ev_desc_rd_err (ev[2]),
        .ev_data_rd_err (ev[3]),
        .ev_data_wr_err (ev[4]),
        .ev_bad_desc    (ev[5]),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .rd_addr        (rd_addr),
        .rd_data        (rd_data),
        .irq_level      (irq_level),
        .msg_valid      (msg_valid),
        .msg_cause      (msg_cause),
        .err_any        (err_any)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One cycle of stimulus: drive at a falling edge, release at the next.
    task automatic step(input logic [5:0] e, input logic w, input logic [11:0] a,
                        input logic [31:0] d);
        ev      = e;
        wr_en   = w;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        ev    = '0;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        rd_addr = a;
        #1 v = rd_data;
        rd_addr = A_STAT;
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        rd(A_STAT, v); check("R9 status", v, 32'h0);
        rd(A_EN, v);   check("R9 enable", v, 32'h0);
        rd(A_CTRL, v); check("R9 control", v, 32'h1);
        check("R9 irq_level", {31'b0, irq_level}, 32'h0);
        check("R9 msg_valid", {31'b0, msg_valid}, 32'h0);
        check("R9 err_any",   {31'b0, err_any},   32'h0);

        // R4 only implemented enable bits store
        step(6'b0, 1'b1, A_EN, 32'hFFFFFFFF);
        rd(A_EN, v); check("R4 enable mask", v, 32'h4E03);

        // Vector walk in wired mode
        for (int i = 0; i < NVEC; i++) begin
            step(VECS[i].ev, VECS[i].wr, VECS[i].addr, VECS[i].data);
            rd(A_STAT, v);
            check($sformatf("R1-table row %0d status", i), v, VECS[i].exp_stat);
            check($sformatf("R5 row %0d irq_level", i), {31'b0, irq_level}, {31'b0, VECS[i].exp_irq});
            check($sformatf("R8 row %0d err_any", i), {31'b0, err_any}, {31'b0, VECS[i].exp_err});
        end

        // R2 clear register reads zero
        rd(A_CLR, v); check("R2 clear reads 0", v, 32'h0);

        // R8 end of block alone does not flag error
        step(6'b0, 1'b1, A_EN, 32'hFFFFFFFF);
        step(6'b000001, 1'b0, 12'h0, 32'h0);
        check("R8 eob only err_any", {31'b0, err_any}, 32'h0);
        check("R5 eob irq_level", {31'b0, irq_level}, 32'h1);

        // R6 control: low 4 bits, message mode silences level
        step(6'b0, 1'b1, A_CTRL, 32'hFFFFFFF0);
        rd(A_CTRL, v); check("R6 control 4 bits", v, 32'h0);
        check("R6 level low in message mode", {31'b0, irq_level}, 32'h0);

        // R7 pulse on new enabled bit, cause = status & enable
        step(6'b010000, 1'b0, 12'h0, 32'h0);
        check("R7 pulse", {31'b0, msg_valid}, 32'h1);
        check("R7 cause", msg_cause, 32'h0801);
        @(negedge clk);
        check("R7 one cycle", {31'b0, msg_valid}, 32'h0);

        // R7 already set bit gives no pulse
        step(6'b010000, 1'b0, 12'h0, 32'h0);
        check("R7 repeat no pulse", {31'b0, msg_valid}, 32'h0);

        // R7 disabled bit gives no pulse, status still records
        step(6'b0, 1'b1, A_CLR, 32'hFFFFFFFF);
        step(6'b0, 1'b1, A_EN, 32'h0800);
        step(6'b100000, 1'b0, 12'h0, 32'h0);
        check("R7 disabled no pulse", {31'b0, msg_valid}, 32'h0);
        rd(A_STAT, v); check("R1 bad desc bit 14", v, 32'h4000);

        // R6 back to wired mode
        step(6'b0, 1'b1, A_CTRL, 32'h5);
        rd(A_CTRL, v); check("R6 control readback", v, 32'h5);
        step(6'b010000, 1'b0, 12'h0, 32'h0);
        check("R6 wired level", {31'b0, irq_level}, 32'h1);
        check("R6 wired no pulse", {31'b0, msg_valid}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule